// File: doc/BRIEF.md
# Slewable TIC and Timemark Generator

This block divides a fast master clock into a periodic TIC strobe. The period is programmed as a high word and a low word, which together form one count in master-clock cycles. Software steers the output toward an external time reference in two ways:

- **Coarse steering.** Software steps the low word up or down. Each step of one lengthens or shortens every TIC period by one master-clock cycle.
- **Fine steering.** Software supplies a 3-bit correction code. The block adds that code to a small phase accumulator at every TIC.

The accumulator value sets the delay of the one-pulse-per-second timemark in whole master-clock cycles. The timemark fires on every tenth TIC. When the accumulator wraps, its carry stretches the TIC period that starts at that moment by one cycle. The carry is also counted in an overflow tally that software can read.

Register writes arrive through a single-cycle load strobe and are staged. A new period therefore applies only from the next TIC boundary, and the period already in progress is never cut short. A synchronous reset restores the default period words and clears the counters. The first TIC then follows on the first clock edge after reset is released.

Top module: `tic_timemark_gen`

## Requirements
- R1: While `rst` is high, the next edge drives `tic`, `pps`, `phase` and `ovf_count` to zero. After release, the first TIC is flagged on the first clock edge, and the following TIC comes after the default period.
- R2: With no accumulator carry, consecutive `tic` pulses are spaced by exactly `hi*2^LO_W + lo` master-clock cycles. The programmed period must be at least 16 cycles.
- R3: A write to either period word does not change the length of the period in progress. It applies from the next TIC boundary.
- R4: `cfg_sel_hi` = 0 loads the low word and `cfg_sel_hi` = 1 loads the high word. Changing either word by one changes the period by one low-word step or by 2^LO_W cycles, respectively.
- R5: On each TIC, `phase` becomes (`phase` + `corr_code`) mod 8. `corr_code` is sampled at the TIC boundary, and `phase` stays unchanged between TICs.
- R6: When that addition carries out of bit 2, the TIC period starting at that boundary is one master-clock cycle longer.
- R7: `ovf_count` increments by one for each carry and changes only together with `tic`.
- R8: `pps` pulses only on every tenth TIC, counting the first TIC after reset as number 0. The other TICs produce no `pps`.
- R9: The rising edge of `pps` lags its `tic` by exactly the `phase` value held before that TIC's addition, in master-clock cycles.
- R10: `pps` stays high for `pulse_len` cycles. A `pulse_len` of 0 gives a 1-cycle pulse.
- R11: `tic` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for a period word |
| cfg_sel_hi | input | 1 | 1 selects the high word, 0 the low word |
| cfg_data | input | DATA_W | Word value to load |
| corr_code | input | PH_W | Per-TIC phase correction, sampled at each boundary |
| pulse_len | input | LEN_W | Timemark pulse width in cycles |
| tic | output | 1 | One-cycle TIC strobe |
| pps | output | 1 | Delayed timemark pulse |
| phase | output | PH_W | Current phase accumulator |
| ovf_count | output | OVF_W | Cumulative accumulator carries |

## Verification
A corrupt period counter shows up within one TIC: the spacing between two `tic` pulses differs from the programmed count, including the one-cycle stretch after a carry. A wrong accumulator or decade count is visible at the next TIC, on `phase` and `ovf_count`, and on the next timemark, whose lag behind `tic` and whose TIC index are both measured. Staging faults appear as a period that changes one TIC too early.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_HIGH = 2'd2
  } pulse_st_t;
endpackage

// File: rtl/tt_period_ctr.sv
module tt_period_ctr #(
  parameter int HI_W   = 8,
  parameter int LO_W   = 16,
  parameter int DATA_W = 16,
  parameter logic [HI_W-1:0] DEF_HI = '0,
  parameter logic [LO_W-1:0] DEF_LO = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel_hi,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              extend,
  output logic              boundary
);
  localparam int PER_W = HI_W + LO_W;

  logic [HI_W-1:0]  hi_q;
  logic [LO_W-1:0]  lo_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] reload;

  assign boundary = (cnt_q == '0);
  assign reload   = {hi_q, lo_q} - PER_W'(1) + PER_W'(extend);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= DEF_HI;
      lo_q  <= DEF_LO;
      cnt_q <= '0;
    end else begin
      if (cfg_wr) begin
        if (cfg_sel_hi) hi_q <= cfg_data[HI_W-1:0];
        else            lo_q <= cfg_data[LO_W-1:0];
      end
      if (boundary) cnt_q <= reload;
      else          cnt_q <= cnt_q - PER_W'(1);
    end
  end
endmodule

// File: rtl/tt_phase_acc.sv
module tt_phase_acc #(
  parameter int PH_W  = 3,
  parameter int OVF_W = 16,
  parameter int DEC_N = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [PH_W-1:0]  code,
  output logic [PH_W-1:0]  phase_q,
  output logic             carry,
  output logic [OVF_W-1:0] ovf_q,
  output logic             mark_sel
);
  localparam int DEC_W = (DEC_N > 1) ? $clog2(DEC_N) : 1;

  logic [PH_W:0]    sum;
  logic [DEC_W-1:0] dec_q;

  assign sum      = {1'b0, phase_q} + {1'b0, code};
  assign carry    = step & sum[PH_W];
  assign mark_sel = (dec_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      ovf_q   <= '0;
      dec_q   <= '0;
    end else if (step) begin
      phase_q <= sum[PH_W-1:0];
      if (sum[PH_W]) ovf_q <= ovf_q + OVF_W'(1);
      if (dec_q == DEC_W'(DEC_N - 1)) dec_q <= '0;
      else                            dec_q <= dec_q + DEC_W'(1);
    end
  end
endmodule

// File: rtl/tt_pulse_shaper.sv
module tt_pulse_shaper
  import tt_pkg::*;
#(
  parameter int PH_W  = 3,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [PH_W-1:0]  delay,
  input  logic [LEN_W-1:0] len,
  output logic             pps_q
);
  localparam int RW = (PH_W > LEN_W) ? PH_W : LEN_W;

  pulse_st_t      st_q;
  logic [RW-1:0]  rem_q;
  logic [RW-1:0]  hold;

  assign hold = (len == '0) ? '0 : RW'(len) - RW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PS_IDLE;
      rem_q <= '0;
      pps_q <= 1'b0;
    end else if (fire) begin
      if (delay == '0) begin
        st_q  <= PS_HIGH;
        rem_q <= hold;
        pps_q <= 1'b1;
      end else begin
        st_q  <= PS_WAIT;
        rem_q <= RW'(delay) - RW'(1);
        pps_q <= 1'b0;
      end
    end else begin
      case (st_q)
        PS_WAIT: begin
          if (rem_q == '0) begin
            st_q  <= PS_HIGH;
            rem_q <= hold;
            pps_q <= 1'b1;
          end else begin
            rem_q <= rem_q - RW'(1);
          end
        end
        PS_HIGH: begin
          if (rem_q == '0) begin
            st_q  <= PS_IDLE;
            pps_q <= 1'b0;
          end else begin
            rem_q <= rem_q - RW'(1);
          end
        end
        default: begin
          st_q  <= PS_IDLE;
          pps_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tic_timemark_gen.sv
module tic_timemark_gen #(
  parameter int HI_W  = 8,
  parameter int LO_W  = 16,
  parameter int PH_W  = 3,
  parameter int LEN_W = 8,
  parameter int OVF_W = 16,
  parameter int DEC_N = 10,
  parameter logic [HI_W-1:0] DEF_HI = 8'h3C,
  parameter logic [LO_W-1:0] DEF_LO = 16'hB823,
  localparam int DATA_W = (HI_W > LO_W) ? HI_W : LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel_hi,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [PH_W-1:0]   corr_code,
  input  logic [LEN_W-1:0]  pulse_len,
  output logic              tic,
  output logic              pps,
  output logic [PH_W-1:0]   phase,
  output logic [OVF_W-1:0]  ovf_count
);
  logic boundary;
  logic carry;
  logic mark_sel;
  logic tic_q;

  tt_period_ctr #(
    .HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W),
    .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)
  ) u_period (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi),
    .cfg_data(cfg_data), .extend(carry), .boundary(boundary)
  );

  tt_phase_acc #(
    .PH_W(PH_W), .OVF_W(OVF_W), .DEC_N(DEC_N)
  ) u_acc (
    .clk(clk), .rst(rst), .step(boundary), .code(corr_code),
    .phase_q(phase), .carry(carry), .ovf_q(ovf_count), .mark_sel(mark_sel)
  );

  tt_pulse_shaper #(
    .PH_W(PH_W), .LEN_W(LEN_W)
  ) u_pulse (
    .clk(clk), .rst(rst), .fire(boundary & mark_sel),
    .delay(phase), .len(pulse_len), .pps_q(pps)
  );

  always_ff @(posedge clk) begin
    if (rst) tic_q <= 1'b0;
    else     tic_q <= boundary;
  end

  assign tic = tic_q;
endmodule

// File: rtl/tic_timemark_gen_chk.sv
module tic_timemark_gen_chk #(
  parameter int PH_W  = 3,
  parameter int OVF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [PH_W-1:0]  corr_code,
  input logic             tic,
  input logic             pps,
  input logic [PH_W-1:0]  phase,
  input logic [OVF_W-1:0] ovf_count
);
  localparam int SW = PH_W + 1;
  localparam logic [SW-1:0] MAXD = SW'((1 << PH_W) - 1);

  logic [SW-1:0] since_tic;

  always_ff @(posedge clk) begin
    if (rst)                 since_tic <= '1;
    else if (tic)            since_tic <= '0;
    else if (since_tic != '1) since_tic <= since_tic + SW'(1);
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!tic && !pps && phase == '0 && ovf_count == '0));

  p_tic_single_r11: assert property (@(posedge clk) disable iff (rst)
    tic |=> !tic);

  p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tic |-> $stable(phase));

  p_phase_step_r5: assert property (@(posedge clk) disable iff (rst)
    tic |-> phase == PH_W'({1'b0, $past(phase)} + {1'b0, $past(corr_code)}));

  p_ovf_with_tic_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_count != $past(ovf_count)) |-> tic);

  p_ovf_carry_r6: assert property (@(posedge clk) disable iff (rst)
    tic |-> (ovf_count - $past(ovf_count)) ==
            OVF_W'((({1'b0, $past(phase)} + {1'b0, $past(corr_code)}) >> PH_W)));

  p_pps_lag_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pps) |-> (tic || since_tic < MAXD));
endmodule

bind tic_timemark_gen tic_timemark_gen_chk #(
  .PH_W(PH_W), .OVF_W(OVF_W)
) u_chk (
  .clk(clk), .rst(rst), .corr_code(corr_code), .tic(tic), .pps(pps),
  .phase(phase), .ovf_count(ovf_count)
);

// File: tb/tic_timemark_gen_tb.sv
module tic_timemark_gen_tb;
  localparam int HI_W = 4, LO_W = 8, PH_W = 3, LEN_W = 4, OVF_W = 8;
  localparam int NV = 12;
  localparam int CODES  [NV] = '{1, 7, 3, 5, 0, 7, 7, 2, 4, 1, 6, 0};
  localparam int EXP_PH [NV] = '{1, 0, 3, 0, 0, 7, 6, 0, 4, 5, 3, 3};
  localparam int EXP_OV [NV] = '{0, 1, 1, 2, 2, 2, 3, 4, 4, 4, 5, 5};
  localparam int EXP_IV [NV] = '{0, 40, 41, 40, 41, 40, 40, 41, 41, 40, 40, 41};

  logic clk = 1'b0, rst = 1'b1, cfg_wr = 1'b0, cfg_sel_hi = 1'b0;
  logic [7:0] cfg_data = '0;
  logic [2:0] corr_code = '0;
  logic [3:0] pulse_len = 4'd3;
  logic tic, pps;
  logic [2:0] phase;
  logic [7:0] ovf_count;

  int cyc = 0, n_chk = 0, n_bad = 0, t_prev = 0, t_now = 0;
  bit done = 0;

  tic_timemark_gen #(
    .HI_W(HI_W), .LO_W(LO_W), .PH_W(PH_W), .LEN_W(LEN_W), .OVF_W(OVF_W),
    .DEC_N(10), .DEF_HI(4'd0), .DEF_LO(8'd40)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi),
    .cfg_data(cfg_data), .corr_code(corr_code), .pulse_len(pulse_len),
    .tic(tic), .pps(pps), .phase(phase), .ovf_count(ovf_count)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tic(output int t);
    do @(negedge clk); while (tic !== 1'b1);
    t = cyc;
  endtask

  task automatic write_word(input bit hi, input int val);
    cfg_sel_hi = hi;
    cfg_data   = 8'(val);
    cfg_wr     = 1'b1;
    @(negedge clk);
    cfg_wr     = 1'b0;
  endtask

  task automatic window(input int exp_d, input int exp_n, input string dreq, input string nreq);
    int first = -1;
    int cnt = 0;
    for (int j = 0; j < 12; j++) begin
      if (j > 0) @(negedge clk);
      if (j == 1) chk("R11 tic width", int'(tic), 0);
      if (pps === 1'b1) begin
        if (first < 0) first = j;
        cnt++;
      end
    end
    if (exp_n > 0) chk(dreq, first, exp_d);
    chk(nreq, cnt, exp_n);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    corr_code = 3'(CODES[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tic in reset", int'(tic), 0);
    chk("R1 pps in reset", int'(pps), 0);
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 ovf in reset", int'(ovf_count), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wait_tic(t_now);
      corr_code = (i < NV - 1) ? 3'(CODES[i + 1]) : 3'd0;
      chk("R5 phase after tic", int'(phase), EXP_PH[i]);
      chk("R7 overflow count", int'(ovf_count), EXP_OV[i]);
      if (i > 0) chk("R6 tic interval", t_now - t_prev, EXP_IV[i]);
      if (i == 0) chk("R1 first tic on first edge", t_now, 4);
      window((i == 0) ? 0 : EXP_PH[i - 1], (i % 10 == 0) ? 3 : 0,
             "R9 pps lag", "R8 pps count");
      t_prev = t_now;
    end

    wait_tic(t_now);
    chk("R2 interval tic12", t_now - t_prev, 40);
    t_prev = t_now;
    write_word(1'b0, 20);
    wait_tic(t_now);
    chk("R3 period in progress kept", t_now - t_prev, 40);
    t_prev = t_now;
    wait_tic(t_now);
    chk("R4 low word applied", t_now - t_prev, 20);
    t_prev = t_now;
    write_word(1'b1, 1);
    write_word(1'b0, 4);
    wait_tic(t_now);
    chk("R3 two writes deferred", t_now - t_prev, 20);
    t_prev = t_now;
    wait_tic(t_now);
    chk("R4 high word applied", t_now - t_prev, 260);

    pulse_len = 4'd0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 phase after mid reset", int'(phase), 0);
    chk("R1 ovf after mid reset", int'(ovf_count), 0);
    chk("R1 pps after mid reset", int'(pps), 0);
    rst = 1'b0;
    wait_tic(t_prev);
    window(0, 1, "R10 zero length lag", "R10 zero length width");
    wait_tic(t_now);
    chk("R1 default period restored", t_now - t_prev, 40);

    done = 1;
    summary();
    $finish;
  end
endmodule